// File: doc/BRIEF.md
# Differential Clock Output Gate Controller

This block decides, for each of a set of buffered clock outputs, whether the output toggles, is parked at a driven level, or is released to high impedance. It takes the reference clock, a polarity strap, one enable pin per output, a stop pin, a power-down pin, and three configuration bytes from a neighbouring register file. Each channel produces a true/complement clock pair and an output-enable for its analog driver. A channel can also run at half the reference rate.

The stop, power-down and enable pins are asynchronous, so they pass through a two-flop synchronizer before they reach the decision logic. The strap flips the active level of all these pins and is captured while reset is held. Every change of a channel's state happens on a rising reference edge, at the point where the true output is already high. A stopped channel therefore always parks with true high and complement low, and no pulse is shorter than half a reference period. In half-rate mode a channel stops only after a completed low phase. It restarts with a full reference cycle held high.

Top module: `diffclk_gate_ctrl`

## Requirements
- R1: While rst_n is low, every clk_oe bit is 0.
- R2: strap_inv is captured while rst_n is low, and later changes of strap_inv have no effect. With a captured 0, pin_oe is active high and pin_stop and pin_pwrdn are active low. With a captured 1, all three polarities are reversed.
- R3: Channels 0, 1, 2 and 3 take their enable bit from cfg_oe bits 1, 2, 5 and 6. A cleared bit tri-states the channel (clk_oe 0), ahead of every other source.
- R4: An inactive enable pin for a channel tri-states that channel.
- R5: When power-down is active, every enabled channel stops. cfg_ctrl bit 7 selects tri-state (1) or parked driven (0).
- R6: When stop is active, a channel stops only if its bit in cfg_stop_en (bits 1, 2, 5, 6 for channels 0 to 3) is 1. cfg_ctrl bit 6 selects tri-state (1) or parked driven (0).
- R7: When power-down and stop are both active, the power-down drive mode decides the channel state.
- R8: A parked driven channel holds clk_t at 1 and clk_c at 0. clk_c is always the inverse of clk_t.
- R9: With cfg_ctrl bit 0 at 1, a running clk_t follows clk_ref. With cfg_ctrl bit 0 at 0, clk_t toggles once per rising edge of clk_ref, so it runs at half the rate.
- R10: A channel takes a new rate setting only while it is not running. A change while it runs takes effect after its next stop.
- R11: A half-rate channel leaves the running state only at an edge that follows a low phase. On restart it stays high for one full reference cycle before its first low phase. No enabled output pulse is shorter than half a reference period.
- R12: A change on a pin reaches the outputs at the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, the source of all outputs |
| rst_n | input | 1 | Active-low reset; strap is captured while low |
| strap_inv | input | 1 | Polarity strap for the enable, stop and power-down pins |
| pin_oe | input | NUM_CH | Per-channel enable pins, asynchronous |
| pin_stop | input | 1 | Stop pin, asynchronous |
| pin_pwrdn | input | 1 | Power-down pin, asynchronous |
| cfg_ctrl | input | 8 | Control byte: bit 7 power-down tri-state, bit 6 stop tri-state, bit 0 full rate |
| cfg_oe | input | 8 | Per-channel enable bits at positions 1, 2, 5, 6 |
| cfg_stop_en | input | 8 | Per-channel stop permission bits at positions 1, 2, 5, 6 |
| clk_t | output | NUM_CH | True clock outputs |
| clk_c | output | NUM_CH | Complement clock outputs |
| clk_oe | output | NUM_CH | Driver enables, 0 means high impedance |

## Verification
The assertions check on every cycle that complement and true outputs stay inverse and that a parked channel sits high. They also check that a cleared enable bit at full rate tri-states the channel on the next edge, that a half-rate stop follows a low phase, and that the divider phase and rate stay frozen under their own conditions. Only the bench scenarios can show the end-to-end decisions: the strap polarity, the priority between disable, power-down and stop, the per-channel stop permission, the three-edge pin latency, and the rate latching across a stop. A runt-pulse monitor covering every enabled output shows that starts and stops are glitch-free.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

  typedef enum logic [1:0] {
    CH_HIZ  = 2'd0,
    CH_PARK = 2'd1,
    CH_RUN  = 2'd2
  } ch_state_e;

  localparam int CTRL_RATE_BIT    = 0;
  localparam int CTRL_STOP_HIZ_BIT = 6;
  localparam int CTRL_PD_HIZ_BIT  = 7;

  // Enable pin: active high with strap 0.
  function automatic logic oe_pin_active(logic level, logic strap);
    return level ^ strap;
  endfunction

  // Stop and power-down pins: active low with strap 0.
  function automatic logic low_pin_active(logic level, logic strap);
    return ~level ^ strap;
  endfunction

  // Priority: disable, then power-down, then stop.
  function automatic ch_state_e pick_state(logic en, logic pd, logic pd_hiz,
                                           logic stp, logic stp_hiz);
    if (!en)  return CH_HIZ;
    if (pd)   return pd_hiz ? CH_HIZ : CH_PARK;
    if (stp)  return stp_hiz ? CH_HIZ : CH_PARK;
    return CH_RUN;
  endfunction

endpackage

// File: rtl/dcg_pin_sync.sv
module dcg_pin_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= async_in;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/dcg_policy.sv
module dcg_policy
  import dcg_pkg::*;
#(
  parameter int               NUM_CH     = 4,
  parameter logic [NUM_CH*3-1:0] CH_BIT_POS = {3'd6, 3'd5, 3'd2, 3'd1}
) (
  input  logic              strap_q,
  input  logic              ready,
  input  logic [NUM_CH-1:0] oe_sync,
  input  logic              stop_sync,
  input  logic              pd_sync,
  input  logic [7:0]        cfg_ctrl,
  input  logic [7:0]        cfg_oe,
  input  logic [7:0]        cfg_stop_en,
  output ch_state_e         target [NUM_CH],
  output logic              div_req
);

  logic pd_act;
  logic stop_act;

  assign pd_act   = low_pin_active(pd_sync, strap_q);
  assign stop_act = low_pin_active(stop_sync, strap_q);
  assign div_req  = ~cfg_ctrl[CTRL_RATE_BIT];

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int POS = int'(CH_BIT_POS[i*3 +: 3]);
      logic en;
      logic stp;
      assign en  = ready && cfg_oe[POS] && oe_pin_active(oe_sync[i], strap_q);
      assign stp = stop_act && cfg_stop_en[POS];
      assign target[i] = pick_state(en, pd_act, cfg_ctrl[CTRL_PD_HIZ_BIT],
                                    stp, cfg_ctrl[CTRL_STOP_HIZ_BIT]);
    end
  endgenerate

endmodule

// File: rtl/dcg_channel.sv
module dcg_channel
  import dcg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ch_state_e target,
  input  logic      div_req,
  output logic      run_o,
  output logic      div_o,
  output logic      phase_o,
  output logic      clk_t,
  output logic      clk_c,
  output logic      clk_oe
);

  ch_state_e st_q;
  ch_state_e st_d;
  logic      div_q;
  logic      phase_q;
  logic      safe;

  // Half-rate running channels may only change at the end of a low phase.
  assign safe = (st_q != CH_RUN) || !div_q || !phase_q;
  assign st_d = safe ? target : st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_HIZ;
      div_q   <= 1'b0;
      phase_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_q == CH_RUN && st_d == CH_RUN && div_q) begin
        phase_q <= ~phase_q;
      end else begin
        phase_q <= 1'b1;
      end
      if (st_q != CH_RUN) begin
        div_q <= div_req;
      end
    end
  end

  assign run_o   = (st_q == CH_RUN);
  assign div_o   = div_q;
  assign phase_o = phase_q;
  assign clk_t   = run_o ? (div_q ? phase_q : clk) : 1'b1;
  assign clk_c   = ~clk_t;
  assign clk_oe  = (st_q != CH_HIZ);

endmodule

// File: rtl/diffclk_gate_ctrl.sv
module diffclk_gate_ctrl
  import dcg_pkg::*;
#(
  parameter int                  NUM_CH      = 4,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [NUM_CH*3-1:0] CH_BIT_POS  = {3'd6, 3'd5, 3'd2, 3'd1}
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              strap_inv,
  input  logic [NUM_CH-1:0] pin_oe,
  input  logic              pin_stop,
  input  logic              pin_pwrdn,
  input  logic [7:0]        cfg_ctrl,
  input  logic [7:0]        cfg_oe,
  input  logic [7:0]        cfg_stop_en,
  output logic [NUM_CH-1:0] clk_t,
  output logic [NUM_CH-1:0] clk_c,
  output logic [NUM_CH-1:0] clk_oe
);

  localparam int SYNC_W = NUM_CH + 2;

  logic                   strap_q;
  logic [SYNC_STAGES-1:0] ready_q;
  logic [SYNC_W-1:0]      sync_w;
  ch_state_e              target_w [NUM_CH];
  logic                   div_req_w;
  logic [NUM_CH-1:0]      ch_run_w;
  logic [NUM_CH-1:0]      ch_div_w;
  logic [NUM_CH-1:0]      ch_phase_w;
  logic                   unused_cfg;

  // Strap is sampled while reset is held and frozen afterwards.
  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      strap_q <= strap_inv;
    end
  end

  // Channels stay tri-stated until the synchronizer holds real pin values.
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= '0;
    end else begin
      ready_q <= {ready_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  dcg_pin_sync #(
    .WIDTH (SYNC_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .async_in({pin_pwrdn, pin_stop, pin_oe}),
    .sync_out(sync_w)
  );

  dcg_policy #(
    .NUM_CH    (NUM_CH),
    .CH_BIT_POS(CH_BIT_POS)
  ) u_policy (
    .strap_q    (strap_q),
    .ready      (ready_q[SYNC_STAGES-1]),
    .oe_sync    (sync_w[NUM_CH-1:0]),
    .stop_sync  (sync_w[NUM_CH]),
    .pd_sync    (sync_w[NUM_CH+1]),
    .cfg_ctrl   (cfg_ctrl),
    .cfg_oe     (cfg_oe),
    .cfg_stop_en(cfg_stop_en),
    .target     (target_w),
    .div_req    (div_req_w)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      dcg_channel u_chan (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .target (target_w[i]),
        .div_req(div_req_w),
        .run_o  (ch_run_w[i]),
        .div_o  (ch_div_w[i]),
        .phase_o(ch_phase_w[i]),
        .clk_t  (clk_t[i]),
        .clk_c  (clk_c[i]),
        .clk_oe (clk_oe[i])
      );
    end
  endgenerate

  assign unused_cfg = ^{cfg_ctrl, cfg_oe, cfg_stop_en};

endmodule

// File: rtl/diffclk_gate_ctrl_chk.sv
module diffclk_gate_ctrl_chk #(
  parameter int                  NUM_CH     = 4,
  parameter logic [NUM_CH*3-1:0] CH_BIT_POS = {3'd6, 3'd5, 3'd2, 3'd1}
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic [7:0]        cfg_oe,
  input logic [NUM_CH-1:0] clk_t,
  input logic [NUM_CH-1:0] clk_c,
  input logic [NUM_CH-1:0] clk_oe,
  input logic [NUM_CH-1:0] ch_run,
  input logic [NUM_CH-1:0] ch_div,
  input logic [NUM_CH-1:0] ch_phase
);

  always @(negedge clk_ref) begin
    if (rst_n === 1'b0) begin
      AST_RESET_HIZ: assert (clk_oe == '0) else $error("enable during reset"); // R1
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      localparam int POS = int'(CH_BIT_POS[i*3 +: 3]);

      AST_COMPLEMENT: assert property (@(posedge clk_ref) disable iff (!rst_n)
        clk_c[i] == ~clk_t[i]) else $error("pair not inverse"); // R8

      AST_PARK_HIGH: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!ch_run[i] && clk_oe[i]) |-> clk_t[i]) else $error("park not high"); // R8

      AST_REG_DISABLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!cfg_oe[POS] && !ch_div[i]) |=> !clk_oe[i]) else $error("disable missed"); // R3

      AST_DIV_STOP_PHASE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($fell(ch_run[i]) && ch_div[i]) |-> !$past(ch_phase[i])) else $error("stop mid high"); // R11

      AST_PHASE_PARKED: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !ch_run[i] |-> ch_phase[i]) else $error("phase not preset"); // R11

      AST_RATE_HOLD: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (ch_run[i] && $past(ch_run[i])) |-> $stable(ch_div[i])) else $error("rate moved"); // R10
    end
  endgenerate

endmodule

bind diffclk_gate_ctrl diffclk_gate_ctrl_chk #(
  .NUM_CH    (NUM_CH),
  .CH_BIT_POS(CH_BIT_POS)
) u_chk (
  .clk_ref (clk_ref),
  .rst_n   (rst_n),
  .cfg_oe  (cfg_oe),
  .clk_t   (clk_t),
  .clk_c   (clk_c),
  .clk_oe  (clk_oe),
  .ch_run  (ch_run_w),
  .ch_div  (ch_div_w),
  .ch_phase(ch_phase_w)
);

// File: tb/diffclk_gate_ctrl_bench.sv
module diffclk_gate_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int S_HIZ = 0;
  localparam int S_PARK = 1;
  localparam int S_RUN = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           strap_inv = 1'b0;
  logic [NCH-1:0] pin_oe = '0;
  logic           pin_stop = 1'b0;
  logic           pin_pwrdn = 1'b0;
  logic [7:0]     cfg_ctrl = 8'h07;
  logic [7:0]     cfg_oe = 8'h66;
  logic [7:0]     cfg_stop_en = 8'h00;
  logic [NCH-1:0] clk_t, clk_c, clk_oe;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  bit mon_en = 0;
  bit done = 0;

  logic           strap_cur = 0;
  logic [NCH-1:0] oe_log = '1;
  logic           stop_log = 0;
  logic           pd_log = 0;
  int             prev_es [NCH];
  logic           exp_div [NCH];

  diffclk_gate_ctrl u_diffclk_gate_ctrl (
    .clk_ref(clk), .rst_n(rst_n), .strap_inv(strap_inv), .pin_oe(pin_oe),
    .pin_stop(pin_stop), .pin_pwrdn(pin_pwrdn), .cfg_ctrl(cfg_ctrl),
    .cfg_oe(cfg_oe), .cfg_stop_en(cfg_stop_en), .clk_t(clk_t), .clk_c(clk_c),
    .clk_oe(clk_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Runt-pulse monitor on enabled outputs (R11).
  realtime        last_chg [NCH];
  logic [NCH-1:0] prev_t = '1;
  always @(clk_t) begin
    for (int i = 0; i < NCH; i++) begin
      if (clk_t[i] !== prev_t[i]) begin
        if (mon_en && clk_oe[i] && ($realtime - last_chg[i] < CLK_PERIOD / 2.0 - 0.01))
          glitches++;
        last_chg[i] = $realtime;
      end
    end
    prev_t = clk_t;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ch_pos(int ch);
    case (ch)
      0: return 1;
      1: return 2;
      2: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic int exp_state(int ch);
    int p = ch_pos(ch);
    if (!cfg_oe[p] || !oe_log[ch]) return S_HIZ;
    if (pd_log) return cfg_ctrl[7] ? S_HIZ : S_PARK;
    if (stop_log && cfg_stop_en[p]) return cfg_ctrl[6] ? S_HIZ : S_PARK;
    return S_RUN;
  endfunction

  task automatic apply_pins();
    for (int i = 0; i < NCH; i++) pin_oe[i] = oe_log[i] ^ strap_cur;
    pin_stop  = ~stop_log ^ strap_cur;
    pin_pwrdn = ~pd_log ^ strap_cur;
  endtask

  task automatic settle();
    for (int k = 0; k < 7; k++) tick();
  endtask

  // Steady-state check of every channel against the bench model.
  task automatic check_all(string tag);
    int es [NCH];
    logic a_t [NCH];
    for (int i = 0; i < NCH; i++) begin
      es[i] = exp_state(i);
      if (prev_es[i] != S_RUN || es[i] != S_RUN) exp_div[i] = ~cfg_ctrl[0];
      prev_es[i] = es[i];
      a_t[i] = clk_t[i];
      chk(clk_oe[i] == (es[i] != S_HIZ), {tag, " oe"}, clk_oe[i], es[i] != S_HIZ);
      if (es[i] != S_HIZ)
        chk(clk_c[i] == ~clk_t[i], "R8 complement", clk_c[i], ~clk_t[i]);
      if (es[i] == S_PARK) chk(clk_t[i] == 1'b1, {tag, " R8 park high"}, clk_t[i], 1);
      if (es[i] == S_RUN && !exp_div[i])
        chk(clk_t[i] == 1'b0, {tag, " R9 full-rate low phase"}, clk_t[i], 0);
    end
    tick();
    for (int i = 0; i < NCH; i++) begin
      if (es[i] == S_RUN && exp_div[i])
        chk(clk_t[i] != a_t[i], {tag, " R9 half-rate toggle"}, clk_t[i], !a_t[i]);
      if (es[i] == S_RUN && !exp_div[i])
        chk(clk_t[i] == 1'b0, {tag, " R10 rate held"}, clk_t[i], 0);
    end
  endtask

  task automatic do_reset(logic strap);
    mon_en = 0;
    rst_n = 0;
    strap_inv = strap;
    strap_cur = strap;
    apply_pins();
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(clk_oe == '0, "R1 reset tri-state", clk_oe, 0);
    end
    rst_n = 1;
    for (int i = 0; i < NCH; i++) begin
      prev_es[i] = S_HIZ;
      exp_div[i] = ~cfg_ctrl[0];
    end
    settle();
    mon_en = 1;
    check_all("R2 post-reset");
  endtask

  task automatic random_phase(int iters);
    for (int n = 0; n < iters; n++) begin
      cfg_ctrl    = 8'($urandom);
      cfg_oe      = 8'($urandom) | 8'($urandom);
      cfg_stop_en = 8'($urandom);
      settle();
      check_all("R3 R5 R6 random cfg");
      for (int i = 0; i < NCH; i++) oe_log[i] = ($urandom % 4) != 0;
      stop_log = 1'($urandom);
      pd_log = ($urandom % 4) == 0;
      apply_pins();
      settle();
      check_all("R4 R7 random pins");
    end
  endtask

  initial begin
    void'($urandom(32'h1d5c_0a17));
    for (int i = 0; i < NCH; i++) last_chg[i] = 0;
    do_reset(1'b0);

    // R12: stop on channel 0 reaches outputs at the third rising edge.
    cfg_ctrl = 8'h01; cfg_oe = 8'h66; cfg_stop_en = 8'h02;
    oe_log = '1; stop_log = 0; pd_log = 0; apply_pins(); settle();
    check_all("R12 setup");
    stop_log = 1; apply_pins();
    tick(); chk(clk_t[0] == 0, "R12 edge1 still running", clk_t[0], 0);
    tick(); chk(clk_t[0] == 0, "R12 edge2 still running", clk_t[0], 0);
    tick(); chk(clk_t[0] == 1, "R12 edge3 parked", clk_t[0], 1);
    chk(clk_t[1] == 0, "R6 channel without permission runs", clk_t[1], 0);
    settle(); check_all("R6 stop permission");

    // R7: both active, power-down drive mode wins.
    cfg_ctrl = 8'h41; cfg_stop_en = 8'h66; pd_log = 1; apply_pins(); settle();
    check_all("R7 pd over stop");
    cfg_ctrl = 8'h81; settle(); check_all("R5 pd tri-state");
    pd_log = 0; stop_log = 0; cfg_ctrl = 8'h01; apply_pins(); settle();
    check_all("R5 pd release");

    // R2: strap changes after reset are ignored.
    strap_inv = 1'b1; settle(); check_all("R2 strap ignored");

    // R10: rate change while running is deferred until the next stop.
    cfg_ctrl = 8'h00; settle(); check_all("R10 deferred");
    pd_log = 1; apply_pins(); settle(); check_all("R10 stopped");
    pd_log = 0; apply_pins();
    tick(); tick(); tick();
    chk(clk_t[0] == 1, "R11 resume held high", clk_t[0], 1);
    tick(); chk(clk_t[0] == 0, "R11 first low", clk_t[0], 0);
    tick(); chk(clk_t[0] == 1, "R11 second high", clk_t[0], 1);
    settle(); check_all("R9 half rate");

    // R3: clearing register enable bit 5 tri-states channel 2 only.
    cfg_oe = 8'h46; settle(); check_all("R3 reg disable");
    cfg_oe = 8'h66;
    oe_log = 4'b1110; apply_pins(); settle(); check_all("R4 pin disable");
    oe_log = '1; apply_pins(); settle();

    random_phase(30);
    do_reset(1'b1);
    random_phase(30);

    chk(glitches == 0, "R11 no runt pulses", glitches, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule